// File: doc/BRIEF.md
# SD Command Issue Engine

This block issues a single SD bus command through a register-style command-path interface and decides whether the command succeeded. A requester supplies a 6-bit command index, a 32-bit argument and four flags: response expected, long response, application command and ignore-CRC. The engine clears the command-path status flags, loads the argument, writes a control word that starts the command path, and waits for the path to drop its active indication. It then writes the control word back to zero, inspects the status, captures the response words and either finishes or tries again.

Failed attempts are retried up to a fixed budget. An application command is preceded by the application-prefix command (index 55) on every attempt; that prefix carries the stored relative card address as its argument and has its own retry budget. If the prefix cannot be completed, the whole request fails at once. A cycle-count limit on the wait for the active indication keeps a stuck command path from hanging the engine. Bit serialisation, CRC generation and the data path live elsewhere.

Top module: `sdcmd_issue_engine`

## Requirements
- R1: After reset, busy, done and done_ok are low, rsp_data is all zero, and no command-path write strobe is raised until a request is accepted.
- R2: A request is accepted only when busy is low; busy rises in the cycle after acceptance and stays high through the done cycle. A request presented while busy is ignored and issues nothing.
- R3: Each attempt begins with one cycle in which cp_clr_we (with cp_clr_data = 0x7FF) and cp_arg_we are both high, followed in the next cycle by the starting control-word write.
- R4: The starting control word puts the command index in bits 5:0, sets bit 6 when a short or long response is expected, sets bit 7 for a long response, and sets bit 10 to start the command path; all other bits are zero.
- R5: Once cp_active is low, the engine writes a control word of zero and judges the status in the following cycle; every attempt ends with exactly one zero write.
- R6: With a response expected, word 0 of cp_resp is captured into rsp_data[31:0] on every judged attempt. Status bit 1 (response timeout) or bit 0 (CRC failure) makes the attempt fail and retry, except that bit 0 with the ignore-CRC flag set ends the request at once with failure.
- R7: A response-expected attempt succeeds only when status bit 2 (response end) is set with bits 0 and 1 clear; for a long response, words 1 to 3 of cp_resp are then captured into rsp_data bits 127:32 (word k at bits 32k+31:32k).
- R8: With no response expected, an attempt succeeds when status bit 3 (command sent) is set, and otherwise retries.
- R9: A request makes at most 6 attempts of its main command and then finishes with failure.
- R10: With the application flag set, every main attempt is preceded by index 55 with argument card_rca and a short response; the prefix may itself take up to 6 attempts, and if all of them fail the request ends with failure and no main command is sent.
- R11: If cp_active stays high for WAIT_LIMIT cycles, the attempt is abandoned with a zero control write, counts as failed, and captures no response word.
- R12: done is a single-cycle pulse, and done_ok in that cycle reports success (1) or failure (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_index | input | IDX_W | Command index |
| req_arg | input | DATA_W | Command argument |
| req_rsp | input | 1 | Short response expected |
| req_long | input | 1 | Long (four-word) response expected |
| req_app | input | 1 | Application command, needs prefix |
| req_nocrc | input | 1 | Ignore CRC failure on the response |
| card_rca | input | DATA_W | Relative card address used as prefix argument |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Result of the request, valid with done |
| rsp_data | output | 4*DATA_W | Captured response words |
| cp_clr_we | output | 1 | Status clear write strobe |
| cp_clr_data | output | 11 | Status clear mask |
| cp_arg_we | output | 1 | Argument write strobe |
| cp_arg_data | output | DATA_W | Argument value |
| cp_ctl_we | output | 1 | Control word write strobe |
| cp_ctl_data | output | 11 | Control word value |
| cp_active | input | 1 | Command path busy with a command |
| cp_status | input | 4 | Command path status flags |
| cp_resp | input | 4*DATA_W | Command path response words |

## Verification
A wrong attempt counter or phase flag shows at the command-path ports as a wrong number or order of starting control writes, or as a prefix sent with the wrong index or argument, visible within the attempt where the state goes astray. A misjudged status shows as an extra or missing attempt and a wrong done_ok on the done pulse. A capture enable raised at the wrong time leaves a stale or unexpected word in rsp_data at the end of the request, so the response words are compared after every request.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  // Control word and status layout of the command path
  localparam int CTL_W        = 11;
  localparam int CLR_W        = 11;
  localparam int JST_W        = 4;
  localparam int CTL_RESP_BIT = 6;
  localparam int CTL_LONG_BIT = 7;
  localparam int CTL_EN_BIT   = 10;
  localparam int ST_CRC_BIT   = 0;
  localparam int ST_TMO_BIT   = 1;
  localparam int ST_END_BIT   = 2;
  localparam int ST_SENT_BIT  = 3;

  typedef struct packed {
    logic resp;
    logic long_rsp;
    logic app;
    logic nocrc;
  } cmd_flags_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PREP,
    S_ISSUE,
    S_WAIT,
    S_STOP,
    S_JUDGE
  } seq_state_t;

  typedef enum logic [1:0] {
    V_RETRY,
    V_SUCC,
    V_HALT
  } verdict_t;

endpackage

// File: rtl/sdcmd_rst_sync.sv
module sdcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/sdcmd_ctlword.sv
module sdcmd_ctlword
  import sdcmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             want_rsp,
  input  logic             want_long,
  input  logic             start,
  output logic [CTL_W-1:0] word
);
  always_comb begin
    word = '0;
    if (start) begin
      word[IDX_W-1:0]    = idx;
      word[CTL_RESP_BIT] = want_rsp | want_long;
      word[CTL_LONG_BIT] = want_long;
      word[CTL_EN_BIT]   = 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge
  import sdcmd_pkg::*;
(
  input  logic [JST_W-1:0] status,
  input  logic             want_rsp,
  input  logic             skip_crc,
  input  logic             stuck,
  output verdict_t         verdict
);
  logic bad_rsp;

  assign bad_rsp = status[ST_CRC_BIT] | status[ST_TMO_BIT];

  always_comb begin
    verdict = V_RETRY;
    if (!stuck) begin
      if (want_rsp) begin
        if (bad_rsp) begin
          if (status[ST_CRC_BIT] && skip_crc) verdict = V_HALT;
        end else if (status[ST_END_BIT]) begin
          verdict = V_SUCC;
        end
      end else if (status[ST_SENT_BIT]) begin
        verdict = V_SUCC;
      end
    end
  end
endmodule

// File: rtl/sdcmd_capture.sv
module sdcmd_capture #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_first,
  input  logic                    cap_rest,
  input  logic [WORDS*DATA_W-1:0] words_in,
  output logic [WORDS*DATA_W-1:0] words_q
);
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic              en;
    logic [DATA_W-1:0] word_q;

    assign en = (k == 0) ? cap_first : cap_rest;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= words_in[k*DATA_W +: DATA_W];
    end

    assign words_q[k*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 32,
  parameter int MAX_TRIES  = 6,
  parameter int WAIT_LIMIT = 32,
  parameter int APP_IDX    = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_arg,
  input  cmd_flags_t        req_flags,
  input  logic [DATA_W-1:0] rca,
  input  logic              cp_active,
  input  verdict_t          verdict,
  output logic              busy,
  output logic              done,
  output logic              done_ok,
  output logic              clr_we,
  output logic              arg_we,
  output logic [DATA_W-1:0] arg_data,
  output logic              ctl_we,
  output logic              ctl_start,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_rsp,
  output logic              cur_long,
  output logic              cur_nocrc,
  output logic              stuck,
  output logic              cap_first,
  output logic              cap_rest
);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(MAX_TRIES - 1);
  localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(WAIT_LIMIT - 1);
  localparam logic [IDX_W-1:0]  APP_CODE  = IDX_W'(APP_IDX);

  seq_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] arg_q, arg_d;
  logic [DATA_W-1:0] rca_q, rca_d;
  cmd_flags_t        flg_q, flg_d;
  logic              pre_q, pre_d;
  logic [TRY_W-1:0]  main_try_q, main_try_d;
  logic [TRY_W-1:0]  pre_try_q, pre_try_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              stuck_q, stuck_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;

  // Fields of the command in flight: the prefix or the main command
  assign cur_idx   = pre_q ? APP_CODE : idx_q;
  assign cur_rsp   = pre_q | flg_q.resp | flg_q.long_rsp;
  assign cur_long  = ~pre_q & flg_q.long_rsp;
  assign cur_nocrc = ~pre_q & flg_q.nocrc;
  assign arg_data  = pre_q ? rca_q : arg_q;
  assign stuck     = stuck_q;
  assign busy      = (state_q != S_IDLE) | done_q;
  assign done      = done_q;
  assign done_ok   = ok_q;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    arg_d      = arg_q;
    rca_d      = rca_q;
    flg_d      = flg_q;
    pre_d      = pre_q;
    main_try_d = main_try_q;
    pre_try_d  = pre_try_q;
    wait_d     = wait_q;
    stuck_d    = stuck_q;
    done_d     = 1'b0;
    ok_d       = ok_q;
    clr_we     = 1'b0;
    arg_we     = 1'b0;
    ctl_we     = 1'b0;
    ctl_start  = 1'b0;
    cap_first  = 1'b0;
    cap_rest   = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (req_valid && !done_q) begin
          idx_d      = req_idx;
          arg_d      = req_arg;
          rca_d      = rca;
          flg_d      = req_flags;
          pre_d      = req_flags.app;
          main_try_d = '0;
          pre_try_d  = '0;
          state_d    = S_PREP;
        end
      end
      S_PREP: begin
        clr_we  = 1'b1;
        arg_we  = 1'b1;
        stuck_d = 1'b0;
        state_d = S_ISSUE;
      end
      S_ISSUE: begin
        ctl_we    = 1'b1;
        ctl_start = 1'b1;
        wait_d    = '0;
        state_d   = S_WAIT;
      end
      S_WAIT: begin
        if (!cp_active) begin
          state_d = S_STOP;
        end else if (wait_q == LAST_WAIT) begin
          stuck_d = 1'b1;
          state_d = S_STOP;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      S_STOP: begin
        ctl_we  = 1'b1;
        state_d = S_JUDGE;
      end
      S_JUDGE: begin
        cap_first = cur_rsp & ~stuck_q;
        cap_rest  = cur_long & (verdict == V_SUCC);
        if (pre_q) begin
          if (verdict == V_SUCC) begin
            pre_d   = 1'b0;
            state_d = S_PREP;
          end else if (pre_try_q == LAST_TRY) begin
            ok_d    = 1'b0;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            pre_try_d = pre_try_q + 1'b1;
            state_d   = S_PREP;
          end
        end else begin
          if (verdict == V_SUCC) begin
            ok_d    = 1'b1;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else if (verdict == V_HALT || main_try_q == LAST_TRY) begin
            ok_d    = 1'b0;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            main_try_d = main_try_q + 1'b1;
            pre_d      = flg_q.app;
            pre_try_d  = '0;
            state_d    = S_PREP;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      arg_q      <= '0;
      rca_q      <= '0;
      flg_q      <= '0;
      pre_q      <= 1'b0;
      main_try_q <= '0;
      pre_try_q  <= '0;
      wait_q     <= '0;
      stuck_q    <= 1'b0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      arg_q      <= arg_d;
      rca_q      <= rca_d;
      flg_q      <= flg_d;
      pre_q      <= pre_d;
      main_try_q <= main_try_d;
      pre_try_q  <= pre_try_d;
      wait_q     <= wait_d;
      stuck_q    <= stuck_d;
      done_q     <= done_d;
      ok_q       <= ok_d;
    end
  end
endmodule

// File: rtl/sdcmd_issue_engine.sv
module sdcmd_issue_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 32,
  parameter int MAX_TRIES  = 6,
  parameter int WAIT_LIMIT = 32,
  parameter int APP_IDX    = 55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_index,
  input  logic [DATA_W-1:0]   req_arg,
  input  logic                req_rsp,
  input  logic                req_long,
  input  logic                req_app,
  input  logic                req_nocrc,
  input  logic [DATA_W-1:0]   card_rca,
  output logic                busy,
  output logic                done,
  output logic                done_ok,
  output logic [4*DATA_W-1:0] rsp_data,
  output logic                cp_clr_we,
  output logic [CLR_W-1:0]    cp_clr_data,
  output logic                cp_arg_we,
  output logic [DATA_W-1:0]   cp_arg_data,
  output logic                cp_ctl_we,
  output logic [CTL_W-1:0]    cp_ctl_data,
  input  logic                cp_active,
  input  logic [JST_W-1:0]    cp_status,
  input  logic [4*DATA_W-1:0] cp_resp
);
  localparam int RSP_WORDS = 4;

  logic             rst_n_int;
  cmd_flags_t       flags;
  verdict_t         verdict;
  logic             ctl_start;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_rsp;
  logic             cur_long;
  logic             cur_nocrc;
  logic             stuck;
  logic             cap_first;
  logic             cap_rest;

  assign flags       = '{resp: req_rsp, long_rsp: req_long, app: req_app, nocrc: req_nocrc};
  assign cp_clr_data = '1;

  sdcmd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sdcmd_seq #(
    .IDX_W      (IDX_W),
    .DATA_W     (DATA_W),
    .MAX_TRIES  (MAX_TRIES),
    .WAIT_LIMIT (WAIT_LIMIT),
    .APP_IDX    (APP_IDX)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_idx   (req_index),
    .req_arg   (req_arg),
    .req_flags (flags),
    .rca       (card_rca),
    .cp_active (cp_active),
    .verdict   (verdict),
    .busy      (busy),
    .done      (done),
    .done_ok   (done_ok),
    .clr_we    (cp_clr_we),
    .arg_we    (cp_arg_we),
    .arg_data  (cp_arg_data),
    .ctl_we    (cp_ctl_we),
    .ctl_start (ctl_start),
    .cur_idx   (cur_idx),
    .cur_rsp   (cur_rsp),
    .cur_long  (cur_long),
    .cur_nocrc (cur_nocrc),
    .stuck     (stuck),
    .cap_first (cap_first),
    .cap_rest  (cap_rest)
  );

  sdcmd_ctlword #(.IDX_W(IDX_W)) u_ctl (
    .idx       (cur_idx),
    .want_rsp  (cur_rsp),
    .want_long (cur_long),
    .start     (ctl_start),
    .word      (cp_ctl_data)
  );

  sdcmd_judge u_judge (
    .status   (cp_status),
    .want_rsp (cur_rsp),
    .skip_crc (cur_nocrc),
    .stuck    (stuck),
    .verdict  (verdict)
  );

  sdcmd_capture #(.DATA_W(DATA_W), .WORDS(RSP_WORDS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cap_first (cap_first),
    .cap_rest  (cap_rest),
    .words_in  (cp_resp),
    .words_q   (rsp_data)
  );
endmodule

// File: rtl/sdcmd_issue_checks.sv
module sdcmd_issue_checks #(
  parameter int MAX_TRIES = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        cp_clr_we,
  input logic        cp_arg_we,
  input logic        cp_ctl_we,
  input logic [10:0] cp_ctl_data
);
  localparam int LIMIT = MAX_TRIES * (MAX_TRIES + 1);
  localparam int CW    = $clog2(LIMIT + 2);

  logic [CW-1:0] start_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          start_cnt <= '0;
    else if (!busy)                      start_cnt <= '0;
    else if (cp_ctl_we && cp_ctl_data[10]) start_cnt <= start_cnt + 1'b1;
  end

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cp_ctl_we && !cp_clr_we && !cp_arg_we));

  assert_busy_from_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_done_within_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_start_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_ctl_we && cp_ctl_data[10]) |-> $past(cp_clr_we && cp_arg_we));

  assert_judge_gap_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_ctl_we && cp_ctl_data == 11'd0) |=> (!cp_ctl_we && !cp_clr_we));

  assert_attempt_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_cnt <= CW'(LIMIT));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sdcmd_issue_engine sdcmd_issue_checks #(.MAX_TRIES(MAX_TRIES)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .done        (done),
  .cp_clr_we   (cp_clr_we),
  .cp_arg_we   (cp_arg_we),
  .cp_ctl_we   (cp_ctl_we),
  .cp_ctl_data (cp_ctl_data)
);

// File: tb/sdcmd_issue_engine_bench.sv
module sdcmd_issue_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;
  localparam int DATA_W     = 32;

  // Scripted outcomes of the command path model
  localparam int O_OK = 0, O_TMO = 1, O_CRC = 2, O_NOEND = 3, O_STUCK = 4;

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic [IDX_W-1:0]    req_index;
  logic [DATA_W-1:0]   req_arg;
  logic                req_rsp, req_long, req_app, req_nocrc;
  logic [DATA_W-1:0]   card_rca;
  logic                busy, done, done_ok;
  logic [4*DATA_W-1:0] rsp_data;
  logic                cp_clr_we, cp_arg_we, cp_ctl_we;
  logic [10:0]         cp_clr_data, cp_ctl_data;
  logic [DATA_W-1:0]   cp_arg_data;
  logic                cp_active;
  logic [3:0]          cp_status;
  logic [4*DATA_W-1:0] cp_resp;

  sdcmd_issue_engine u_sdcmd_issue_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_arg(req_arg), .req_rsp(req_rsp), .req_long(req_long), .req_app(req_app),
    .req_nocrc(req_nocrc), .card_rca(card_rca), .busy(busy), .done(done),
    .done_ok(done_ok), .rsp_data(rsp_data), .cp_clr_we(cp_clr_we),
    .cp_clr_data(cp_clr_data), .cp_arg_we(cp_arg_we), .cp_arg_data(cp_arg_data),
    .cp_ctl_we(cp_ctl_we), .cp_ctl_data(cp_ctl_data), .cp_active(cp_active),
    .cp_status(cp_status), .cp_resp(cp_resp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int script [64];
  int base = 0;

  // Command path model state
  int          n_iss;
  int          n_zero;
  int          n_clrbad;
  logic        m_active;
  int          m_cnt;
  int          m_out;
  logic        m_rspexp;
  logic [10:0] m_status;
  logic [DATA_W-1:0] m_arg;
  logic [4*DATA_W-1:0] m_resp;
  logic [10:0] log_ctl [64];
  logic [31:0] log_arg [64];

  assign cp_active = m_active;
  assign cp_status = m_status[3:0];
  assign cp_resp   = m_resp;

  function automatic logic [31:0] word_val(int n, int k);
    return 32'h5A00_0000 ^ (32'(n) << 8) ^ 32'(k * 17 + 1);
  endfunction

  function automatic logic [10:0] status_for(int o, logic r);
    logic [10:0] s;
    s = '0;
    if (r) begin
      if (o == O_OK)  s[2] = 1'b1;
      if (o == O_TMO) s[1] = 1'b1;
      if (o == O_CRC) s[0] = 1'b1;
    end else if (o == O_OK) begin
      s[3] = 1'b1;
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int pos;
    if (!rst_n) begin
      n_iss <= 0; n_zero <= 0; n_clrbad <= 0;
      m_active <= 1'b0; m_cnt <= 0; m_out <= 0; m_rspexp <= 1'b0;
      m_status <= '0; m_arg <= '0; m_resp <= '0;
    end else begin
      if (cp_clr_we) begin
        m_status <= m_status & ~cp_clr_data;
        if (cp_clr_data != 11'h7FF) n_clrbad <= n_clrbad + 1;
      end
      if (cp_arg_we) m_arg <= cp_arg_data;
      if (cp_ctl_we) begin
        if (cp_ctl_data[10]) begin
          pos = (n_iss - base) % 64;
          log_ctl[pos] <= cp_ctl_data;
          log_arg[pos] <= m_arg;
          m_out    <= script[pos];
          m_cnt    <= 1 + (n_iss % 3);
          m_active <= 1'b1;
          m_rspexp <= cp_ctl_data[6];
          n_iss    <= n_iss + 1;
        end else begin
          m_active <= 1'b0;
          n_zero   <= n_zero + 1;
        end
      end else if (m_active) begin
        if (m_cnt != 0) begin
          m_cnt <= m_cnt - 1;
        end else if (m_out != O_STUCK) begin
          m_active <= 1'b0;
          m_status <= status_for(m_out, m_rspexp);
          m_resp   <= {word_val(n_iss - 1, 3), word_val(n_iss - 1, 2),
                       word_val(n_iss - 1, 1), word_val(n_iss - 1, 0)};
        end
      end
    end
  end

  // Expected behaviour derived from the requirements
  logic [10:0] exp_ctl [64];
  logic [31:0] exp_arg [64];
  logic [31:0] exp_w [4];
  logic        exp_ok;
  int          exp_n;

  // 0 retry, 1 success, 2 halt
  function automatic int judge(int o, logic r, logic nc);
    if (o == O_STUCK) return 0;
    if (r) begin
      if (o == O_CRC) return nc ? 2 : 0;
      if (o == O_OK) return 1;
      return 0;
    end
    return (o == O_OK) ? 1 : 0;
  endfunction

  function automatic logic [10:0] ctl_of(logic [5:0] i, logic r, logic l);
    return {1'b1, 2'b00, l, r | l, i};
  endfunction

  task automatic ref_cmd(logic [5:0] idx, logic [31:0] arg, logic r, logic l,
                         logic app, logic nc);
    int p = 0;
    bit fin = 0;
    bit pre_ok;
    int v;
    exp_ok = 1'b0;
    for (int a = 0; a < 6 && !fin; a++) begin
      if (app) begin
        pre_ok = 0;
        for (int b = 0; b < 6 && !pre_ok; b++) begin
          exp_ctl[p] = ctl_of(6'd55, 1'b1, 1'b0);
          exp_arg[p] = card_rca;
          if (script[p] != O_STUCK) exp_w[0] = word_val(base + p, 0);
          if (judge(script[p], 1'b1, 1'b0) == 1) pre_ok = 1;
          p++;
        end
        if (!pre_ok) fin = 1;
      end
      if (!fin) begin
        exp_ctl[p] = ctl_of(idx, r, l);
        exp_arg[p] = arg;
        v = judge(script[p], r | l, nc);
        if (script[p] != O_STUCK && (r | l)) exp_w[0] = word_val(base + p, 0);
        if (v == 1 && l) for (int k = 1; k < 4; k++) exp_w[k] = word_val(base + p, k);
        p++;
        if (v == 1) begin exp_ok = 1'b1; fin = 1; end
        else if (v == 2) fin = 1;
      end
    end
    exp_n = p;
  endtask

  task automatic chk(bit cond, string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_vec++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic fill(int o);
    for (int i = 0; i < 64; i++) script[i] = o;
  endtask

  task automatic run_cmd(string tag, logic [5:0] idx, logic [31:0] arg, logic r,
                         logic l, logic app, logic nc, bit poke);
    int zbase;
    int cyc;
    base  = n_iss;
    zbase = n_zero;
    ref_cmd(idx, arg, r, l, app, nc);
    @(negedge clk);
    req_index = idx; req_arg = arg; req_rsp = r; req_long = l;
    req_app = app; req_nocrc = nc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", 128'(busy), 128'd1);
    if (poke) begin
      req_index = ~idx; req_arg = ~arg; req_app = 1'b0; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R12", "done seen", 128'(done), 128'd1);
    chk(done_ok == exp_ok, tag, "done_ok", 128'(done_ok), 128'(exp_ok));
    chk(n_iss - base == exp_n, (app ? "R10" : "R9"), "attempt count",
        128'(n_iss - base), 128'(exp_n));
    chk(n_zero - zbase == exp_n, "R5", "zero control writes",
        128'(n_zero - zbase), 128'(exp_n));
    for (int p = 0; p < exp_n && p < 64; p++) begin
      chk(log_ctl[p] == exp_ctl[p], "R4", "control word", 128'(log_ctl[p]), 128'(exp_ctl[p]));
      chk(log_arg[p] == exp_arg[p], "R3", "argument", 128'(log_arg[p]), 128'(exp_arg[p]));
    end
    chk(rsp_data[31:0] == exp_w[0], "R6", "response word 0",
        128'(rsp_data[31:0]), 128'(exp_w[0]));
    chk(rsp_data[127:32] == {exp_w[3], exp_w[2], exp_w[1]}, "R7", "response words 1-3",
        128'(rsp_data[127:32]), 128'({exp_w[3], exp_w[2], exp_w[1]}));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12", "single done pulse",
        128'({done, busy}), 128'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R12: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int fail_pct;
    void'($urandom(32'd20251));
    req_valid = 0; req_index = '0; req_arg = '0; req_rsp = 0; req_long = 0;
    req_app = 0; req_nocrc = 0; card_rca = 32'h1234_0000;
    for (int k = 0; k < 4; k++) exp_w[k] = '0;
    fill(O_OK);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0 && done_ok == 1'b0, "R1", "control outputs",
        128'({busy, done, done_ok}), 128'd0);
    chk(rsp_data == '0, "R1", "response words", rsp_data, 128'd0);
    chk(n_iss == 0 && n_zero == 0, "R1", "no command-path writes", 128'(n_iss + n_zero), 128'd0);

    // Directed corner cases
    fill(O_OK);  run_cmd("R7", 6'd17, 32'h0000_1000, 1, 0, 0, 0, 0);
    fill(O_TMO); run_cmd("R9", 6'd13, 32'hABCD_0001, 1, 0, 0, 0, 0);
    fill(O_CRC); script[5] = O_OK; run_cmd("R7", 6'd9, 32'h0BAD_F00D, 1, 1, 0, 0, 0);
    fill(O_CRC); run_cmd("R6", 6'd41, 32'h00FF_8000, 1, 0, 0, 1, 0);
    fill(O_CRC); script[2] = O_OK; run_cmd("R6", 6'd41, 32'h00FF_8000, 1, 0, 0, 0, 0);
    fill(O_OK);  run_cmd("R8", 6'd0, 32'h0, 0, 0, 0, 0, 0);
    fill(O_NOEND); script[1] = O_OK; run_cmd("R8", 6'd7, 32'h0, 0, 0, 0, 0, 0);
    fill(O_TMO); run_cmd("R10", 6'd41, 32'h40FF_8000, 1, 0, 1, 1, 0);
    fill(O_OK); script[1] = O_TMO; run_cmd("R10", 6'd6, 32'h2, 1, 0, 1, 0, 0);
    fill(O_OK); script[0] = O_STUCK; run_cmd("R11", 6'd3, 32'h77, 1, 0, 0, 0, 0);
    fill(O_STUCK); run_cmd("R11", 6'd8, 32'h1AA, 1, 0, 0, 0, 0);
    fill(O_OK); run_cmd("R2", 6'd24, 32'h55AA, 1, 0, 0, 0, 1);
    fill(O_OK); run_cmd("R4", 6'd2, 32'h0, 0, 1, 0, 0, 0);

    // Constrained random requests
    for (int t = 0; t < 150; t++) begin
      fail_pct = $urandom_range(0, 90);
      for (int i = 0; i < 64; i++) begin
        if ($urandom_range(0, 99) < fail_pct) begin
          script[i] = $urandom_range(1, 4);
          if (script[i] == O_STUCK && $urandom_range(0, 3) != 0) script[i] = O_TMO;
        end else begin
          script[i] = O_OK;
        end
      end
      card_rca = {$urandom_range(0, 65535), 16'h0000};
      run_cmd("R9", 6'($urandom_range(0, 63)), $urandom, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    chk(n_clrbad == 0, "R3", "status clear mask", 128'(n_clrbad), 128'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule